// File: doc/BRIEF.md
# Link Receive Deframer

This block sits on the receive side of a byte-wide chip-to-chip link, in the receive clock domain. Each cycle it takes one byte and one frame strobe. It finds the first byte of a transaction at a rising edge of the frame strobe. It gathers the following bytes into a 104-bit transaction record and presents the finished record for one cycle with a valid strobe. Capture at the pins and the crossing into the system clock are done by other blocks.

The first byte carries a control nibble, a two-bit access-size code and a write flag. These decide whether the transaction is 9 bytes long (indices 0 to 8) or 13 bytes long (indices 0 to 12). If the strobe is still high on the edge after the last byte, the link is streaming. That byte then becomes index 5 of a new transaction. The new transaction reuses the previous header, and its target address moves on by the access size.

Two wait outputs, one for reads and one for writes, tell the sender to hold off. A wait output asserts two edges after the last byte of a transaction of its own type is captured, provided the matching downstream buffer reports almost full. The deframer keeps accepting traffic while a wait output is high.

Top module: `lrx_deframer`

## Requirements
- R1: A transaction starts only on an edge where the frame strobe is sampled high after being sampled low on the edge before. A strobe that is already high when reception is enabled starts nothing until it has gone low and then high again.
- R2: Byte 0 is decoded as follows: bits [7:4] are the control field, bits [3:2] are the size code (00=1 byte, 01=2, 10=4, 11=8) and bit [1] is the write flag. Bytes 1..4 form the target address, most significant byte first. Bytes 5..8 form the data word, most significant byte first. The output record packs, from bit 0 upward: access (1), write (1), size (2), control (4), target address (32), data (32), source (32).
- R3: A write with size code 11 is 13 bytes long, and bytes 9..12 fill the source field, most significant byte first. Every other transaction is 9 bytes long and reports a source field of zero.
- R4: Each finished transaction sets `pkt_valid` for exactly one cycle. This is the cycle after the edge that captured its last byte, and the access bit of the record is 1 in that cycle.
- R5: If the strobe is high on the edge after a last byte, that byte is index 5 of a new transaction. The new transaction keeps the control, size and write fields, and its target address is the previous one plus the access size in bytes, wrapping modulo 2^32.
- R6: If the strobe is low on the edge after a last byte, the deframer goes idle. A single low sample is enough to re-arm the start detector, so a new byte 0 may follow on the next edge.
- R7: If the strobe goes low before the last byte of a transaction, that transaction is dropped and produces no output.
- R8: `rd_wait` (`wr_wait`) rises on the second edge after the edge that captured the last byte of a read (write) transaction, if `rd_almost_full` (`wr_almost_full`) is high in the cycle between. An almost-full input alone, or a transaction of the other type, never raises it.
- R9: A wait output stays high while its almost-full input stays high, and falls on the first edge at which that input is sampled low.
- R10: Transactions received while a wait output is high are still assembled and emitted normally.
- R11: While `rx_en` is low, no transaction starts and any transaction in progress is abandoned with no output.
- R12: During and right after reset, `pkt_valid`, `rd_wait` and `wr_wait` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Reception enable |
| rx_frame | input | 1 | Frame strobe sampled with each byte |
| rx_byte | input | 8 | Received byte lane |
| rd_almost_full | input | 1 | Downstream read buffer nearly full |
| wr_almost_full | input | 1 | Downstream write buffer nearly full |
| pkt_valid | output | 1 | One-cycle strobe for a finished transaction |
| pkt_data | output | 104 | Assembled transaction record |
| rd_wait | output | 1 | Hold-off request for read traffic |
| wr_wait | output | 1 | Hold-off request for write traffic |

## Verification
The bench drives each byte half a cycle ahead of the edge that captures it. It files the expected record together with the cycle in which that record is due, which is one edge after the last byte is captured. The monitor compares both the record and the cycle number. Wait outputs are checked in the valid cycle, where they must still be low, and again one edge later, where they must be high. The release of a wait output is checked one edge after its almost-full input is cleared. Dropped and ignored traffic is checked by comparing the count of emitted records with the count of expected records after the strobe has settled low.

// File: rtl/lrx_pkg.sv
`timescale 1ns/1ps
package lrx_pkg;
    localparam int LANE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / LANE_W;
    localparam int IDX_W      = 4;
    localparam int DST_FIRST  = 1;
    localparam int DATA_FIRST = DST_FIRST + WORD_BYTES;
    localparam int SRC_FIRST  = DATA_FIRST + WORD_BYTES;
    localparam int SHORT_LAST = SRC_FIRST - 1;
    localparam int LONG_LAST  = SRC_FIRST + WORD_BYTES - 1;
    localparam logic [1:0] SIZE_DBL = 2'b11;
    localparam int N_KINDS    = 2;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] dst;
        logic [3:0]        ctrl;
        logic [1:0]        size;
        logic              wr;
        logic              access;
    } pkt_t;

    typedef struct packed {
        logic              busy;
        logic              strm;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [3:0]        ctrl;
        logic [1:0]        size;
        logic              wr;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] src;
        logic              vld;
    } asm_t;
endpackage

// File: rtl/lrx_edge.sv
`timescale 1ns/1ps
module lrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = frame_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign rise_o = frame_i & ~prev_q;
endmodule

// File: rtl/lrx_asm.sv
`timescale 1ns/1ps
module lrx_asm
    import lrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              frame_i,
    input  logic              start_i,
    input  logic [LANE_W-1:0] byte_i,
    output logic              vld_o,
    output pkt_t              pkt_o
);
    asm_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!en_i) begin
            st_d.busy = 1'b0;
            st_d.strm = 1'b0;
        end else if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.strm = 1'b0;
                st_d.ctrl = byte_i[7:4];
                st_d.size = byte_i[3:2];
                st_d.wr   = byte_i[1];
                st_d.last = (byte_i[1] && byte_i[3:2] == SIZE_DBL)
                            ? IDX_W'(LONG_LAST) : IDX_W'(SHORT_LAST);
                st_d.idx  = IDX_W'(DST_FIRST);
                st_d.dst  = '0;
                st_d.data = '0;
                st_d.src  = '0;
            end
        end else if (!frame_i) begin
            st_d.busy = 1'b0;
            st_d.strm = 1'b0;
        end else begin
            if (st_q.strm) begin
                st_d.dst  = st_q.dst + (WORD_W'(1) << st_q.size);
                st_d.data = '0;
                st_d.src  = '0;
                st_d.strm = 1'b0;
            end
            for (int k = 0; k < WORD_BYTES; k++) begin
                if (st_q.idx == IDX_W'(DST_FIRST + k))
                    st_d.dst[WORD_W-LANE_W*(k+1) +: LANE_W] = byte_i;
                if (st_q.idx == IDX_W'(DATA_FIRST + k))
                    st_d.data[WORD_W-LANE_W*(k+1) +: LANE_W] = byte_i;
                if (st_q.idx == IDX_W'(SRC_FIRST + k))
                    st_d.src[WORD_W-LANE_W*(k+1) +: LANE_W] = byte_i;
            end
            if (st_q.idx == st_q.last) begin
                st_d.vld  = 1'b1;
                st_d.idx  = IDX_W'(DATA_FIRST);
                st_d.strm = 1'b1;
            end else begin
                st_d.idx  = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    always_comb begin
        pkt_o.src    = st_q.src;
        pkt_o.data   = st_q.data;
        pkt_o.dst    = st_q.dst;
        pkt_o.ctrl   = st_q.ctrl;
        pkt_o.size   = st_q.size;
        pkt_o.wr     = st_q.wr;
        pkt_o.access = st_q.vld;
    end

    // R4: a record is never presented on two cycles in a row
    a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);
    // R11: a disabled receiver emits nothing on the next cycle
    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !st_q.vld);
    // R7: a strobe drop during a transaction yields no record
    a_r7_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !frame_i) |=> !st_q.vld);
    // R3: short transactions report a zero source field
    a_r3_short_src: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.last == IDX_W'(SHORT_LAST)) |-> (pkt_o.src == '0));
endmodule

// File: rtl/lrx_wait.sv
`timescale 1ns/1ps
module lrx_wait (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic afull_i,
    output logic wait_o
);
    logic wait_d, wait_q;

    always_comb begin
        wait_d = afull_i ? (wait_q | hit_i) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wait_q <= 1'b0;
        else        wait_q <= wait_d;
    end

    assign wait_o = wait_q;

    // R8: a wait output rises only right after a matching finished record
    a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_q) |-> $past(hit_i));
    // R9: a cleared almost-full releases the wait on the next edge
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        !afull_i |=> !wait_q);
    // R9: the wait holds while almost-full stays high
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && afull_i) |=> wait_q);
endmodule

// File: rtl/lrx_deframer.sv
`timescale 1ns/1ps
module lrx_deframer
    import lrx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_en,
    input  logic                       rx_frame,
    input  logic [LANE_W-1:0]          rx_byte,
    input  logic                       rd_almost_full,
    input  logic                       wr_almost_full,
    output logic                       pkt_valid,
    output logic [$bits(pkt_t)-1:0]    pkt_data,
    output logic                       rd_wait,
    output logic                       wr_wait
);
    logic start;
    logic vld;
    pkt_t pkt;
    logic [N_KINDS-1:0] hit, afull, wt;

    lrx_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (rx_frame),
        .rise_o  (start)
    );

    lrx_asm i_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (rx_en),
        .frame_i (rx_frame),
        .start_i (start),
        .byte_i  (rx_byte),
        .vld_o   (vld),
        .pkt_o   (pkt)
    );

    // index 0 serves reads, index 1 serves writes
    assign hit[0]   = vld & ~pkt.wr;
    assign hit[1]   = vld &  pkt.wr;
    assign afull[0] = rd_almost_full;
    assign afull[1] = wr_almost_full;

    for (genvar g = 0; g < N_KINDS; g++) begin : g_wait
        lrx_wait i_wait (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (hit[g]),
            .afull_i (afull[g]),
            .wait_o  (wt[g])
        );
    end

    assign pkt_valid = vld;
    assign pkt_data  = pkt;
    assign rd_wait   = wt[0];
    assign wr_wait   = wt[1];
endmodule

// File: tb/test_lrx_deframer.sv
`timescale 1ns/1ps
module test_lrx_deframer;
    logic clk = 1'b0;
    logic rst_n;
    logic rx_en, rx_frame, rd_af, wr_af;
    logic [7:0] rx_byte;
    logic pkt_valid, rd_wait, wr_wait;
    logic [103:0] pkt_data;

    always #10 clk = ~clk;

    lrx_deframer i_lrx_deframer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_frame(rx_frame),
        .rx_byte(rx_byte), .rd_almost_full(rd_af), .wr_almost_full(wr_af),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .rd_wait(rd_wait), .wr_wait(wr_wait)
    );

    typedef struct {
        logic [103:0] pkt;
        int           due;
        string        tag;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0, cyc = 0, seen = 0, pushed = 0;
    bit done = 0;

    logic [3:0]  cur_ctrl;
    logic [1:0]  cur_size;
    logic        cur_wr;
    logic [31:0] cur_dst, cur_data, cur_src;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a record appears
    always @(negedge clk) begin
        if (rst_n === 1'b1 && pkt_valid === 1'b1) begin
            seen++;
            if (q.size() == 0) begin
                chk(0, "R4 unexpected record", pkt_data, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(pkt_data === e.pkt, e.tag, pkt_data, e.pkt);
                chk(cyc == e.due, {e.tag, " R4 timing"}, cyc, e.due);
            end
        end
    end

    task automatic tick(input logic f, input logic [7:0] b);
        rx_frame = f;
        rx_byte  = b;
        @(negedge clk);
    endtask

    function automatic int last_idx();
        return (cur_wr && cur_size == 2'b11) ? 12 : 8;
    endfunction

    function automatic logic [7:0] byte_of(int k);
        if (k == 0)      return {cur_ctrl, cur_size, cur_wr, 1'b0};
        else if (k <= 4) return cur_dst[8*(4-k) +: 8];
        else if (k <= 8) return cur_data[8*(8-k) +: 8];
        else             return cur_src[8*(12-k) +: 8];
    endfunction

    task automatic send_range(input int first, input string tag);
        int lst;
        lst = last_idx();
        for (int k = first; k <= lst; k++) begin
            if (k == lst) begin
                exp_t e;
                e.pkt = {(lst == 12) ? cur_src : 32'h0, cur_data, cur_dst,
                         cur_ctrl, cur_size, cur_wr, 1'b1};
                e.due = cyc + 1;
                e.tag = tag;
                q.push_back(e);
                pushed++;
            end
            tick(1'b1, byte_of(k));
        end
    endtask

    task automatic send_fresh(input logic [3:0] c, input logic [1:0] s,
                              input logic w, input logic [31:0] d,
                              input logic [31:0] dt, input logic [31:0] sr,
                              input string tag);
        cur_ctrl = c; cur_size = s; cur_wr = w;
        cur_dst = d; cur_data = dt; cur_src = sr;
        send_range(0, tag);
    endtask

    task automatic send_stream(input logic [31:0] dt, input logic [31:0] sr,
                               input string tag);
        cur_dst  = cur_dst + (32'd1 << cur_size);
        cur_data = dt; cur_src = sr;
        send_range(5, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rx_en = 1; rx_frame = 0; rx_byte = 0; rd_af = 0; wr_af = 0;
        repeat (3) @(negedge clk);
        chk(pkt_valid === 1'b0, "R12 valid in reset", pkt_valid, 0);
        chk({rd_wait, wr_wait} === 2'b00, "R12 waits in reset", {rd_wait, wr_wait}, 0);
        rst_n = 1;
        tick(0, 0);
        chk({pkt_valid, rd_wait, wr_wait} === 3'b000, "R12 after reset",
            {pkt_valid, rd_wait, wr_wait}, 0);

        // R2 / R3 short formats
        send_fresh(4'hA, 2'b10, 1, 32'h1234_5678, 32'hCAFE_F00D, 32'hDEAD_BEEF, "R2 word write");
        tick(0, 0);
        send_fresh(4'h3, 2'b00, 0, 32'h8000_0001, 32'h0102_0304, 32'h5555_AAAA, "R3 byte read src zero");
        tick(0, 0);
        send_fresh(4'h7, 2'b11, 1, 32'h0000_1000, 32'h89AB_CDEF, 32'h7654_3210, "R3 double write long");
        tick(0, 0);

        // R5 streaming, short and long
        send_fresh(4'h5, 2'b01, 1, 32'h0000_0100, 32'h1111_2222, 0, "R5 stream head");
        send_stream(32'h3333_4444, 0, "R5 stream second addr+2");
        send_stream(32'h5555_6666, 0, "R5 stream third addr+4");
        tick(0, 0);
        send_fresh(4'h9, 2'b11, 1, 32'hFFFF_FFF8, 32'hA0A0_A0A0, 32'hB1B1_B1B1, "R5 long head");
        send_stream(32'hC2C2_C2C2, 32'hD3D3_D3D3, "R5 long stream wrap");
        tick(0, 0);

        // R6 one low sample re-arms
        send_fresh(4'h1, 2'b10, 0, 32'h0000_0040, 32'h0, 0, "R6 first");
        tick(0, 0);
        send_fresh(4'h2, 2'b10, 0, 32'h0000_0080, 32'h0, 0, "R6 restart after one low");
        tick(0, 0);

        // R1 strobe already high at enable
        rx_en = 0;
        tick(0, 0);
        tick(1, 8'h02);
        rx_en = 1;
        cur_ctrl = 4'h4; cur_size = 2'b10; cur_wr = 1; cur_dst = 32'h10; cur_data = 32'h20;
        for (int k = 0; k <= 10; k++) tick(1, byte_of(k));
        tick(0, 0); tick(0, 0);
        chk(seen == pushed, "R1 no start without rising edge", seen, pushed);

        // R7 strobe drop mid transaction, then a short broken burst
        for (int k = 0; k <= 4; k++) tick(1, byte_of(k));
        tick(0, 0);
        for (int k = 5; k <= 8; k++) tick(1, byte_of(k));
        tick(0, 0); tick(0, 0);
        chk(seen == pushed, "R7 dropped transaction", seen, pushed);
        send_fresh(4'h6, 2'b10, 1, 32'h0000_0200, 32'h7777_8888, 0, "R7 recovery");
        tick(0, 0);

        // R11 disable mid transaction
        for (int k = 0; k <= 5; k++) tick(1, byte_of(k));
        rx_en = 0;
        tick(1, byte_of(6));
        rx_en = 1;
        tick(1, byte_of(7)); tick(1, byte_of(8));
        tick(0, 0); tick(0, 0);
        chk(seen == pushed, "R11 abandoned when disabled", seen, pushed);

        // R8 almost-full alone does nothing
        rd_af = 1;
        tick(0, 0); tick(0, 0); tick(0, 0);
        chk(rd_wait === 1'b0, "R8 no rise without record", rd_wait, 0);

        // R8 read wait timing
        send_fresh(4'h0, 2'b10, 0, 32'h0000_0300, 0, 0, "R8 read record");
        chk(rd_wait === 1'b0, "R8 low in valid cycle", rd_wait, 0);
        tick(0, 0);
        chk(rd_wait === 1'b1, "R8 high two edges after last byte", rd_wait, 1);
        chk(wr_wait === 1'b0, "R8 write wait untouched by read", wr_wait, 0);

        // R10 still accepted, R9 holds
        send_fresh(4'h8, 2'b01, 0, 32'h0000_0400, 32'h0000_ABCD, 0, "R10 accepted while waiting");
        tick(0, 0); tick(0, 0);
        chk(rd_wait === 1'b1, "R9 held while almost full", rd_wait, 1);
        rd_af = 0;
        tick(0, 0);
        chk(rd_wait === 1'b0, "R9 released", rd_wait, 0);

        // R8 write wait, read wait ignores write records
        rd_af = 1; wr_af = 1;
        send_fresh(4'hF, 2'b10, 1, 32'h0000_0500, 32'h1357_9BDF, 0, "R8 write record");
        tick(0, 0);
        chk(wr_wait === 1'b1, "R8 write wait raised", wr_wait, 1);
        chk(rd_wait === 1'b0, "R8 read wait not raised by write", rd_wait, 0);
        rd_af = 0; wr_af = 0;
        tick(0, 0);
        chk(wr_wait === 1'b0, "R9 write wait released", wr_wait, 0);

        repeat (4) tick(0, 0);
        chk(q.size() == 0, "R4 all expected records seen", q.size(), 0);
        chk(seen == pushed, "R4 record count", seen, pushed);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule